// File: doc/BRIEF.md
# Segmentable Tapped Shift Register Pair

The block holds two independent 64-stage shift registers. Each has its own clock, serial input, mode input, three tap inputs and four tap outputs. Every rising edge of a channel's clock captures the serial input into stage 1 and moves each bit one stage toward higher index. Taps sit after stages 16, 32, 48 and 64.

When the channel's `load` input is low, the 64 stages form one serial chain and the four tap output enables are high. When `load` is high, the enables drop and the chain splits into four 16-stage segments. The heads of segments two to four (stages 17, 33 and 49) then take their bits from `tap_in`, so a full 64-bit image loads in 16 edges. The tristate tap pins are modelled as separate value, enable and input ports. There is no reset, and the contents hold for as long as no clock edge occurs.

Top module: `seg_shift64`

## Requirements
- R1: Stages are numbered 1 to 64 and shift toward higher index. `tap_out[j]` shows stage 16*(j+1): bit 0 is stage 16, bit 1 is stage 32, bit 2 is stage 48 and bit 3 is stage 64. In serial mode a bit entered on one edge appears on `tap_out[3]` 64 edges later, and not on the edge before that.
- R2: Every rising edge captures the serial input into stage 1, whatever the level of `load`.
- R3: With `load` low, stages 17, 33 and 49 take the value of stages 16, 32 and 48, so the channel acts as one 64-stage chain.
- R4: All four bits of `tap_oe` are 1 while `load` is low and 0 while it is high.
- R5: With `load` high, stages 17, 33 and 49 take `tap_in[0]`, `tap_in[1]` and `tap_in[2]` on each edge.
- R6: `tap_in` has no effect while `load` is low.
- R7: Sixteen edges in load mode fill all 64 stages. If bit 15-t of words w0..w3 is fed on load edge t through serial input, `tap_in[0]`, `tap_in[1]` and `tap_in[2]`, a serial readout of `tap_out[3]` that samples, then shifts, 64 times yields {w3,w2,w1,w0}, MSB first.
- R8: `tap_out` carries the stage values in both modes; only `tap_oe` reflects the tristate.
- R9: Without a clock edge, changes on `din`, `load` and `tap_in` leave the contents unchanged.
- R10: The two channels are independent: edges and inputs of one never change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Channel A clock, rising edge |
| din_a | input | 1 | Channel A serial input into stage 1 |
| load_a | input | 1 | Channel A mode: 1 = segmented load, 0 = serial |
| tap_in_a | input | 3 | Channel A inputs for stages 17, 33, 49 |
| tap_out_a | output | 4 | Channel A values of stages 16, 32, 48, 64 |
| tap_oe_a | output | 4 | Channel A tap output enables |
| clk_b | input | 1 | Channel B clock, rising edge |
| din_b | input | 1 | Channel B serial input into stage 1 |
| load_b | input | 1 | Channel B mode: 1 = segmented load, 0 = serial |
| tap_in_b | input | 3 | Channel B inputs for stages 17, 33, 49 |
| tap_out_b | output | 4 | Channel B values of stages 16, 32, 48, 64 |
| tap_oe_b | output | 4 | Channel B tap output enables |

## Verification
`tap_oe` is combinational from `load` and is due at once. Each tap value is registered and changes on the edge it follows, so a bit entered at stage 1 reaches tap j after 16*(j+1) edges. The bench drives inputs while the clock is low, raises it and samples after the falling half. Every check therefore sees the state after exactly the counted number of edges. The single-bit latency test samples tap 64 after edge 63 and again after edge 64, so an off-by-one in either direction shows up.

// File: rtl/seg_shift64.sv
module seg_shift64 #(
  parameter int SEG_LEN = 16,
  parameter int NSEG    = 4
) (
  input  logic            clk_a,
  input  logic            din_a,
  input  logic            load_a,
  input  logic [NSEG-2:0] tap_in_a,
  output logic [NSEG-1:0] tap_out_a,
  output logic [NSEG-1:0] tap_oe_a,
  input  logic            clk_b,
  input  logic            din_b,
  input  logic            load_b,
  input  logic [NSEG-2:0] tap_in_b,
  output logic [NSEG-1:0] tap_out_b,
  output logic [NSEG-1:0] tap_oe_b
);
  localparam int DEPTH = SEG_LEN * NSEG;

  logic [DEPTH-1:0] sr_a, sr_b, nx_a, nx_b;
  logic [NSEG-1:0]  hd_a, hd_b;

  assign hd_a[0] = din_a;
  assign hd_b[0] = din_b;

  for (genvar s = 1; s < NSEG; s++) begin : g_head
    assign hd_a[s] = load_a ? tap_in_a[s-1] : sr_a[s*SEG_LEN-1];
    assign hd_b[s] = load_b ? tap_in_b[s-1] : sr_b[s*SEG_LEN-1];
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign nx_a[s*SEG_LEN +: SEG_LEN] = {sr_a[s*SEG_LEN +: SEG_LEN-1], hd_a[s]};
    assign nx_b[s*SEG_LEN +: SEG_LEN] = {sr_b[s*SEG_LEN +: SEG_LEN-1], hd_b[s]};
    assign tap_out_a[s] = sr_a[(s+1)*SEG_LEN-1];
    assign tap_out_b[s] = sr_b[(s+1)*SEG_LEN-1];
  end

  assign tap_oe_a = {NSEG{~load_a}};
  assign tap_oe_b = {NSEG{~load_b}};

  always_ff @(posedge clk_a) sr_a <= nx_a;
  always_ff @(posedge clk_b) sr_b <= nx_b;
endmodule

// File: rtl/seg_shift64_chk.sv
module seg_shift64_chk #(
  parameter int NSEG = 4
) (
  input logic            clk,
  input logic            din,
  input logic            load,
  input logic            tin0,
  input logic            st1,
  input logic            st2,
  input logic            seg_tail,
  input logic            seg_head,
  input logic [NSEG-1:0] oe
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_STAGE1_CAPTURE: assert property (@(posedge clk) disable iff (!armed)
    st1 === $past(din)); // R2
  AST_INNER_SHIFT: assert property (@(posedge clk) disable iff (!armed)
    st2 === $past(st1)); // R1
  AST_SERIAL_JOIN: assert property (@(posedge clk) disable iff (!armed)
    !$past(load) |-> seg_head === $past(seg_tail)); // R3
  AST_LOAD_HEAD: assert property (@(posedge clk) disable iff (!armed)
    $past(load) |-> seg_head === $past(tin0)); // R5
  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!armed)
    ($countones(oe) == 0) || ($countones(oe) == NSEG)); // R4
endmodule

bind seg_shift64 seg_shift64_chk #(.NSEG(NSEG)) u_chk_a (
  .clk(clk_a), .din(din_a), .load(load_a), .tin0(tap_in_a[0]),
  .st1(sr_a[0]), .st2(sr_a[1]), .seg_tail(sr_a[SEG_LEN-1]),
  .seg_head(sr_a[SEG_LEN]), .oe(tap_oe_a));

bind seg_shift64 seg_shift64_chk #(.NSEG(NSEG)) u_chk_b (
  .clk(clk_b), .din(din_b), .load(load_b), .tin0(tap_in_b[0]),
  .st1(sr_b[0]), .st2(sr_b[1]), .seg_tail(sr_b[SEG_LEN-1]),
  .seg_head(sr_b[SEG_LEN]), .oe(tap_oe_b));

// File: tb/tb_seg_shift64.sv
module tb_seg_shift64;
  logic       clk_a = 0, din_a = 0, load_a = 0;
  logic [2:0] tin_a = 0;
  logic       clk_b = 0, din_b = 0, load_b = 0;
  logic [2:0] tin_b = 0;
  logic [3:0] tout_a, oe_a, tout_b, oe_b;
  logic [63:0] ma, mb;
  int total = 0, bad = 0;

  seg_shift64 dut (
    .clk_a(clk_a), .din_a(din_a), .load_a(load_a), .tap_in_a(tin_a),
    .tap_out_a(tout_a), .tap_oe_a(oe_a),
    .clk_b(clk_b), .din_b(din_b), .load_b(load_b), .tap_in_b(tin_b),
    .tap_out_b(tout_b), .tap_oe_b(oe_b));

  function automatic logic [63:0] nxt(logic [63:0] m, logic d, logic ld, logic [2:0] ti);
    logic [63:0] r;
    r = {m[62:0], d};
    if (ld) begin r[16] = ti[0]; r[32] = ti[1]; r[48] = ti[2]; end
    return r;
  endfunction

  function automatic logic [3:0] taps(logic [63:0] m);
    return {m[63], m[47], m[31], m[15]};
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 4 ns period per edge: 250 MHz
  task automatic edge_ab(bit ea, bit eb);
    #1;
    if (ea) ma = nxt(ma, din_a, load_a, tin_a);
    if (eb) mb = nxt(mb, din_b, load_b, tin_b);
    clk_a = ea; clk_b = eb;
    #2;
    clk_a = 0; clk_b = 0;
    #1;
  endtask

  task automatic cmp_all(string tag);
    check({oe_a, tout_a}, {{4{~load_a}}, taps(ma)}, {tag, " chA"});
    check({oe_b, tout_b}, {{4{~load_b}}, taps(mb)}, {tag, " chB"});
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w [4];
    logic [63:0] got;
    logic [3:0]  held;
    void'($urandom(32'h5EED_0042));
    ma = '0; mb = '0;
    #2;
    // flush: no reset, so the starting state is defined by 64 zero shifts
    for (int i = 0; i < 64; i++) edge_ab(1, 1);
    check({oe_a, tout_a}, 8'hF0, "R1 flushed taps A");
    check({oe_b, tout_b}, 8'hF0, "R1 flushed taps B");

    // R1: single 1 reaches tap j after 16*(j+1) edges
    din_a = 1; edge_ab(1, 0); din_a = 0;
    for (int e = 2; e <= 64; e++) begin
      edge_ab(1, 0);
      if (e == 16) check(tout_a, 4'b0001, "R1 tap16 at edge 16");
      if (e == 32) check(tout_a, 4'b0010, "R1 tap32 at edge 32");
      if (e == 63) check(tout_a, 4'b0000, "R1 tap64 not yet at edge 63");
    end
    check(tout_a, 4'b1000, "R1 tap64 at edge 64");
    check(tout_b, 4'b0000, "R10 B untouched by A edges");
    for (int i = 0; i < 64; i++) edge_ab(1, 0);

    // R6: tap_in ignored in serial mode
    tin_a = 3'b111;
    for (int i = 0; i < 16; i++) edge_ab(1, 0);
    check(tout_a, 4'b0000, "R6 tap_in ignored when serial");
    tin_a = 0;

    // R4, R7, R8: segmented load of four words
    for (int k = 0; k < 4; k++) w[k] = 16'($urandom);
    w[0] = 16'h8001;
    load_a = 1; #1;
    check(oe_a, 4'b0000, "R4 oe low in load mode");
    for (int t = 0; t < 16; t++) begin
      din_a = w[0][15-t]; tin_a = {w[3][15-t], w[2][15-t], w[1][15-t]};
      edge_ab(1, 0);
    end
    check(tout_a, {w[3][15], w[2][15], w[1][15], w[0][15]}, "R8 taps valued in load mode");
    load_a = 0; din_a = 0; tin_a = 3'b101; #1;
    check(oe_a, 4'b1111, "R4 oe high in serial mode");
    got = '0;
    for (int i = 0; i < 64; i++) begin
      got = {got[62:0], tout_a[3]};
      if (i < 63) edge_ab(1, 0);
    end
    check(got[63:56], {w[3][15:8]}, "R7 readout w3 high");
    check(got[7:0], {w[0][7:0]}, "R7 readout w0 low");
    check(got[39:32], {w[2][7:0]}, "R7 readout w2 low");
    cmp_all("R7 model after readout");

    // R9: hold without an edge
    held = tout_a;
    din_a = 1; tin_a = 3'b111; load_a = 1; #40;
    load_a = 0; din_a = 0; #40;
    check(tout_a, held, "R9 held without clock");

    // R2: stage 1 captures din in load mode too (seen 16 edges later on tap16)
    load_a = 1; din_a = 1; edge_ab(1, 0); din_a = 0;
    for (int i = 1; i < 16; i++) edge_ab(1, 0);
    check(tout_a[0], 1'b1, "R2 din captured in load mode");
    load_a = 0;

    // random mix: R3 R5 R8 R10 against the model
    for (int n = 0; n < 3000; n++) begin
      bit ea, eb;
      din_a = 1'($urandom); din_b = 1'($urandom);
      load_a = ($urandom % 4) == 0; load_b = ($urandom % 3) == 0;
      tin_a = 3'($urandom); tin_b = 3'($urandom);
      ea = ($urandom % 4) != 0; eb = ($urandom % 4) != 1;
      edge_ab(ea, eb);
      cmp_all("R3 R5 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule